// File: doc/BRIEF.md
# Drive Tag and Bus Gate Timer

This block times the command handshake between a disk controller's state sequencer and a disk drive. When the sequencer raises any of its start requests, the block runs a short timing cycle on a 1 MHz tick derived from the system clock. The cycle produces two bus-enable gates, which place command data on the drive bus, and two tag strobes, which latch that data into the drive. A one-clock cycle-complete pulse goes back to the sequencer at the end.

The tag sequence is kept in an enable flop and two Gray-coded bits. A copy of the first bit, delayed by 200 ns, forms the first bus gate. That gate therefore opens before the first tag strobe and closes after it. When the sequencer is in a read or write state, the second tag strobe and the second bus gate stay asserted until the transfer ends. Only then is the cycle-complete pulse sent.

The block also generates the following:
- cylinder and head bus strobes;
- cylinder-set and head-set strobes;
- read-gate and write-gate flops;
- an erase gate that stays on for a fixed time after the write state ends.

Top module: `tag_gate_timer`

## Requirements
- R1: While `rst` is high, every output is 0 after each clock edge.
- R2: A high bit on `start_req`, sampled at clock edge t0 while the block is idle, begins a cycle. Idle means no cycle is running and tag gate 2 is not held. Tick n of the tag sequence falls on edge t0+1+(n-1)·T, with T = CLK_HZ/1e6. Every gate output changes one clock after the tag state changes.
- R3: Call {bit1,bit2} the two Gray bits. They step 10, 11, 01, 00 on ticks 1 to 4, and tick 5 clears the enable flop. `tag_gate1` is high while the code is 11 with the enable flop set, which is edges t0+2+T up to t0+2+2T.
- R4: `bus_gate1` is the enable flop ANDed with bit1 delayed by D = CLK_HZ/5e6 clocks. It rises at t0+2+D and falls at t0+2+2T+D, so it brackets `tag_gate1` on both sides.
- R5: `bus_gate2` is NOT delayed bit1, ANDed with (enable OR (read-or-erase AND `tag_gate2`)). This gives a D-clock pulse from t0+2, and the gate rises again at t0+2+2T+D.
- R6: `tag_gate2` rises at t0+2+3T.
  - Without a transfer, `tag_gate2` and `bus_gate2` fall at t0+2+4T.
  - `cyc_done` is a single-clock pulse at t0+3+4T.
- R7: If read-or-erase is high, `tag_gate2` and `bus_gate2` are held past tick 5. Read-or-erase is `op_read` OR `erase_gate`.
  - Both fall on the first edge at which read-or-erase is sampled low.
  - `cyc_done` pulses one clock after that edge.
- R8: The two transfer gates follow their states:
  - `read_gate` sets one clock after tick 2 while `op_read` is high, and clears on the first edge at which `op_read` is sampled low.
  - `write_gate` does the same with `op_write`.
- R9: `erase_gate` sets one clock after `write_gate`. Let W be the first edge at which `op_write` is sampled low; `erase_gate` clears at edge W+E−1, with E = T·ERASE_US.
- R10: The strobes are registered alongside the gates.
  - `cyl_strobe` = `op_seek` AND bus gate 1.
  - `head_strobe` = read-or-erase AND bus gate 1.
  - `set_cyl` = `op_seek` AND tag gate 1.
  - `set_head` = read-or-erase AND `normal_mode` AND tag gate 1.
- R11: A start request that arrives while a cycle runs or while tag gate 2 is held has no effect on the gate timeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | NUM_START | Start requests from the sequencer, ORed together |
| op_seek | input | 1 | Sequencer is in the seek state |
| op_read | input | 1 | Sequencer is in the read state |
| op_write | input | 1 | Sequencer is in the write state |
| normal_mode | input | 1 | Normal (not format) operation |
| bus_gate1 | output | 1 | First bus enable |
| bus_gate2 | output | 1 | Second bus enable |
| tag_gate1 | output | 1 | First tag strobe |
| tag_gate2 | output | 1 | Second tag strobe, held during transfers |
| cyc_done | output | 1 | One-clock cycle-complete pulse |
| cyl_strobe | output | 1 | Cylinder address onto the bus |
| head_strobe | output | 1 | Head address onto the bus |
| set_cyl | output | 1 | Latch cylinder in the drive |
| set_head | output | 1 | Latch head in the drive |
| read_gate | output | 1 | Read gate flop |
| write_gate | output | 1 | Write gate flop |
| erase_gate | output | 1 | Erase gate with trailing extension |

## Verification
The assertions take for granted that the sequencer's state inputs are registered levels that stay stable within a clock. They also assume that `op_read` and `op_write` are never high together. The stimulus raises at most one state input per cycle and changes inputs only on falling clock edges. It drops a read or write state only after tick 5, so the transfer hold is always exercised. Extra start requests are placed both in the middle of a tag cycle and in the hold phase, which are the two busy windows in which a start must be ignored.

// File: rtl/tgt_pkg.sv
package tgt_pkg;

  // Tag state: {enable, bit1, bit2}
  typedef logic [2:0] tag_state_t;

  localparam tag_state_t TS_IDLE = 3'b000;
  localparam tag_state_t TS_LAST = 3'b100;

  // Registered gate bundle
  typedef struct packed {
    logic bg1;
    logic bg2;
    logic tg1;
    logic tg2;
  } gate_set_t;

  // One tick advance of the Gray tag sequence
  function automatic tag_state_t tag_step(tag_state_t s);
    tag_state_t n;
    if (!s[2]) begin
      n = 3'b110;
    end else begin
      case (s[1:0])
        2'b10:   n = 3'b111;
        2'b11:   n = 3'b101;
        2'b01:   n = 3'b100;
        default: n = TS_IDLE;
      endcase
    end
    return n;
  endfunction

endpackage

// File: rtl/tgt_tick_gen.sv
module tgt_tick_gen #(
  parameter int DIV = 125
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_direct
      assign tick = run;
    end else begin : g_count
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (rst || clear) begin
          cnt_q <= '0;
        end else if (run) begin
          cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
      end

      assign tick = run && (cnt_q == '0);
    end
  endgenerate
endmodule

// File: rtl/tgt_lag.sv
module tgt_lag #(
  parameter int LAG = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = (LAG > 1) ? $clog2(LAG) : 1;
  localparam logic [CW-1:0] LAST = CW'(LAG - 1);

  logic [CW-1:0] cnt_q;

  // Output follows input once the input has differed for LAG clocks
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      dout  <= 1'b0;
    end else if (din != dout) begin
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        dout  <= din;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/tgt_erase_timer.sv
module tgt_erase_timer #(
  parameter int HOLD = 2500
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_state,
  input  logic wr_gate,
  output logic erase
);
  localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      erase <= 1'b0;
    end else begin
      if (wr_gate) begin
        erase <= 1'b1;
      end
      if (wr_state) begin
        cnt_q <= '0;
      end else if (erase) begin
        if (cnt_q == LAST) begin
          cnt_q <= '0;
          if (!wr_gate) begin
            erase <= 1'b0;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tag_gate_timer.sv
module tag_gate_timer #(
  parameter int CLK_HZ    = 125_000_000,
  parameter int NUM_START = 7,
  parameter int ERASE_US  = 20
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_START-1:0] start_req,
  input  logic                 op_seek,
  input  logic                 op_read,
  input  logic                 op_write,
  input  logic                 normal_mode,
  output logic                 bus_gate1,
  output logic                 bus_gate2,
  output logic                 tag_gate1,
  output logic                 tag_gate2,
  output logic                 cyc_done,
  output logic                 cyl_strobe,
  output logic                 head_strobe,
  output logic                 set_cyl,
  output logic                 set_head,
  output logic                 read_gate,
  output logic                 write_gate,
  output logic                 erase_gate
);
  import tgt_pkg::*;

  localparam int TICK_CYC  = CLK_HZ / 1_000_000;
  localparam int LAG_CYC   = CLK_HZ / 5_000_000;
  localparam int ERASE_CYC = TICK_CYC * ERASE_US;

  logic       run_q;
  tag_state_t seq_q;
  logic       tick;
  logic       accept;
  logic       bit1_lag;
  logic       rd_er;
  logic       active;
  logic       active_q;
  gate_set_t  gates_n;

  // Start is taken only with the timer fully idle
  assign accept = (|start_req) && !run_q && !seq_q[2] && !tag_gate2;
  assign rd_er  = op_read || erase_gate;

  tgt_tick_gen #(.DIV(TICK_CYC)) i_tick (
    .clk   (clk),
    .rst   (rst),
    .clear (accept),
    .run   (run_q),
    .tick  (tick)
  );

  tgt_lag #(.LAG(LAG_CYC)) i_lag (
    .clk  (clk),
    .rst  (rst),
    .din  (seq_q[1]),
    .dout (bit1_lag)
  );

  tgt_erase_timer #(.HOLD(ERASE_CYC)) i_erase (
    .clk      (clk),
    .rst      (rst),
    .wr_state (op_write),
    .wr_gate  (write_gate),
    .erase    (erase_gate)
  );

  // Tag sequence and tick enable latch
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      seq_q <= TS_IDLE;
    end else begin
      if (accept) begin
        run_q <= 1'b1;
      end else if (tick && seq_q == TS_LAST) begin
        run_q <= 1'b0;
      end
      if (tick) begin
        seq_q <= tag_step(seq_q);
      end
    end
  end

  // Gate decode
  always_comb begin
    gates_n.bg1 = bit1_lag && seq_q[2];
    gates_n.tg1 = seq_q[2] && seq_q[1] && seq_q[0];
    gates_n.tg2 = (seq_q[2] && !seq_q[1] && !seq_q[0]) || (tag_gate2 && rd_er);
    gates_n.bg2 = !bit1_lag && (seq_q[2] || (rd_er && tag_gate2));
  end

  assign active = seq_q[2] || tag_gate2;

  // Registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_gate1   <= 1'b0;
      bus_gate2   <= 1'b0;
      tag_gate1   <= 1'b0;
      tag_gate2   <= 1'b0;
      cyl_strobe  <= 1'b0;
      head_strobe <= 1'b0;
      set_cyl     <= 1'b0;
      set_head    <= 1'b0;
      read_gate   <= 1'b0;
      write_gate  <= 1'b0;
      active_q    <= 1'b0;
      cyc_done    <= 1'b0;
    end else begin
      bus_gate1   <= gates_n.bg1;
      bus_gate2   <= gates_n.bg2;
      tag_gate1   <= gates_n.tg1;
      tag_gate2   <= gates_n.tg2;
      cyl_strobe  <= op_seek && gates_n.bg1;
      head_strobe <= rd_er && gates_n.bg1;
      set_cyl     <= op_seek && gates_n.tg1;
      set_head    <= rd_er && normal_mode && gates_n.tg1;
      read_gate   <= op_read && (read_gate || seq_q[0]);
      write_gate  <= op_write && (write_gate || seq_q[0]);
      active_q    <= active;
      cyc_done    <= active_q && !active;
    end
  end
endmodule

// File: rtl/tag_gate_timer_chk.sv
module tag_gate_timer_chk (
  input logic clk,
  input logic rst,
  input logic op_seek,
  input logic op_read,
  input logic normal_mode,
  input logic bus_gate1,
  input logic bus_gate2,
  input logic tag_gate1,
  input logic tag_gate2,
  input logic cyc_done,
  input logic set_cyl,
  input logic set_head,
  input logic read_gate,
  input logic write_gate,
  input logic erase_gate
);
  // R4: bus gate 1 already open when tag gate 1 starts
  a_r4_bg1_leads_tg1: assert property (@(posedge clk) disable iff (rst)
    $rose(tag_gate1) |-> bus_gate1 && $past(bus_gate1));

  // R4: bus gate 1 still open when tag gate 1 ends
  a_r4_bg1_trails_tg1: assert property (@(posedge clk) disable iff (rst)
    $fell(tag_gate1) |-> bus_gate1);

  // R5: the two bus gates never overlap
  a_r5_bus_gates_apart: assert property (@(posedge clk) disable iff (rst)
    !(bus_gate1 && bus_gate2));

  // R3: tag strobes are mutually exclusive
  a_r3_tag_gates_apart: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tag_gate1, tag_gate2}));

  // R6: completion is a single pulse after tag gate 2 ends
  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    cyc_done |=> !cyc_done);

  a_r6_done_after_tg2: assert property (@(posedge clk) disable iff (rst)
    cyc_done |-> !tag_gate2 && $past(tag_gate2, 2));

  // R8: read gate only while the read state was present
  a_r8_read_gate_needs_read: assert property (@(posedge clk) disable iff (rst)
    read_gate |-> $past(op_read));

  // R9: erase gate follows write gate
  a_r9_erase_after_write_gate: assert property (@(posedge clk) disable iff (rst)
    $rose(write_gate) |=> erase_gate);

  // R10: set strobes sit inside tag gate 1
  a_r10_set_cyl_in_tg1: assert property (@(posedge clk) disable iff (rst)
    set_cyl |-> tag_gate1 && $past(op_seek));

  a_r10_set_head_in_tg1: assert property (@(posedge clk) disable iff (rst)
    set_head |-> tag_gate1 && $past(normal_mode));
endmodule

bind tag_gate_timer tag_gate_timer_chk i_chk (.*);

// File: tb/test_tag_gate_timer.sv
module test_tag_gate_timer;
  localparam int CLK_HZ = 125_000_000;
  localparam int NS     = 7;
  localparam int T      = CLK_HZ / 1_000_000;
  localparam int D      = CLK_HZ / 5_000_000;
  localparam int E      = T * 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] start_req = '0;
  logic          op_seek = 1'b0, op_read = 1'b0, op_write = 1'b0, normal_mode = 1'b0;
  logic bus_gate1, bus_gate2, tag_gate1, tag_gate2, cyc_done;
  logic cyl_strobe, head_strobe, set_cyl, set_head, read_gate, write_gate, erase_gate;

  tag_gate_timer #(.CLK_HZ(CLK_HZ), .NUM_START(NS), .ERASE_US(20)) i_tag_gate_timer (
    .clk(clk), .rst(rst), .start_req(start_req),
    .op_seek(op_seek), .op_read(op_read), .op_write(op_write), .normal_mode(normal_mode),
    .bus_gate1(bus_gate1), .bus_gate2(bus_gate2), .tag_gate1(tag_gate1),
    .tag_gate2(tag_gate2), .cyc_done(cyc_done), .cyl_strobe(cyl_strobe),
    .head_strobe(head_strobe), .set_cyl(set_cyl), .set_head(set_head),
    .read_gate(read_gate), .write_gate(write_gate), .erase_gate(erase_gate)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  typedef struct {
    int         at;
    logic [4:0] vec;
    string      tag;
  } exp_t;
  exp_t q[$];

  wire [4:0] vec = {bus_gate1, bus_gate2, tag_gate1, tag_gate2, cyc_done};
  logic [4:0] last_vec = '0;

  // Monitor: every change of the gate vector is matched against the queue
  always @(negedge clk) begin
    if (!rst && vec !== last_vec) begin
      nchk++;
      if (q.size() == 0) begin
        nfail++;
        $display("FAIL R11: actual change to %b at cycle %0d, expected no change", vec, cyc);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (e.at != cyc || e.vec !== vec) begin
          nfail++;
          $display("FAIL %s: actual %b at cycle %0d, expected %b at cycle %0d",
                   e.tag, vec, cyc, e.vec, e.at);
        end
      end
    end
    last_vec = vec;
  end

  task automatic push(int at, logic [4:0] v, string tag);
    exp_t e;
    e.at = at; e.vec = v; e.tag = tag;
    q.push_back(e);
  endtask

  // Driver: expected gate timeline up to tag gate 2 rising
  task automatic push_head(int t0);
    push(t0 + 2,           5'b01000, "R2");
    push(t0 + 2 + D,       5'b10000, "R4");
    push(t0 + 2 + T,       5'b10100, "R3");
    push(t0 + 2 + 2*T,     5'b10000, "R3");
    push(t0 + 2 + 2*T + D, 5'b01000, "R5");
    push(t0 + 2 + 3*T,     5'b01010, "R6");
  endtask

  task automatic push_end(int x, string tag);
    push(x,     5'b00000, tag);
    push(x + 1, 5'b00001, tag);
    push(x + 2, 5'b00000, tag);
  endtask

  task automatic chk(string tag, logic [11:0] act, logic [11:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic go_to(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic fire(int b, output int t0);
    start_req[b] = 1'b1;
    t0 = cyc + 1;
    @(negedge clk);
    start_req = '0;
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    int t0, tx, x;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk("R1", {bus_gate1, bus_gate2, tag_gate1, tag_gate2, cyc_done, cyl_strobe,
               head_strobe, set_cyl, set_head, read_gate, write_gate, erase_gate}, 12'h000);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // Seek cycle: full non-transfer timeline and cylinder strobes
    op_seek = 1'b1;
    fire(2, t0);
    push_head(t0);
    push_end(t0 + 2 + 4*T, "R6");
    go_to(t0 + 2 + D + 5);
    chk("R10 cyl strobe", 12'(cyl_strobe), 12'h1);
    chk("R10 no set_cyl outside tg1", 12'(set_cyl), 12'h0);
    go_to(t0 + 2 + T + 10);
    chk("R10 set_cyl", 12'(set_cyl), 12'h1);
    chk("R10 no set_head", 12'(set_head), 12'h0);
    chk("R10 no head strobe", 12'(head_strobe), 12'h0);
    go_to(t0 + 4*T + 10);
    op_seek = 1'b0;

    // Plain cycle with late starts that must be ignored (R11)
    fire(0, t0);
    push_head(t0);
    push_end(t0 + 2 + 4*T, "R6");
    go_to(t0 + 200);
    fire(5, tx);
    go_to(t0 + 3*T + 50);
    fire(6, tx);
    go_to(t0 + 4*T + 10);

    // Read transfer: hold and read gate (R7, R8)
    op_read = 1'b1; normal_mode = 1'b1;
    fire(3, t0);
    push_head(t0);
    go_to(t0 + 1 + T);
    chk("R8 read_gate before tick2", 12'(read_gate), 12'h0);
    go_to(t0 + 2 + T);
    chk("R8 read_gate set", 12'(read_gate), 12'h1);
    chk("R8 write_gate idle", 12'(write_gate), 12'h0);
    go_to(t0 + 2 + T + 10);
    chk("R10 set_head", 12'(set_head), 12'h1);
    chk("R10 head strobe", 12'(head_strobe), 12'h1);
    chk("R10 no cyl strobe", 12'(cyl_strobe), 12'h0);
    go_to(t0 + 4*T + 300);
    fire(1, tx);
    go_to(t0 + 4*T + 400);
    chk("R7 tg2 held", 12'(tag_gate2), 12'h1);
    x = cyc + 1;
    push_end(x, "R7");
    op_read = 1'b0;
    go_to(x);
    chk("R8 read_gate cleared", 12'(read_gate), 12'h0);
    go_to(x + 5);

    // Write transfer: erase extension (R9)
    op_write = 1'b1; normal_mode = 1'b0;
    fire(4, t0);
    push_head(t0);
    go_to(t0 + 2 + T);
    chk("R8 write_gate set", 12'(write_gate), 12'h1);
    chk("R9 erase not yet", 12'(erase_gate), 12'h0);
    go_to(t0 + 3 + T);
    chk("R9 erase set", 12'(erase_gate), 12'h1);
    go_to(t0 + 4 + T + 10);
    chk("R10 head strobe via erase", 12'(head_strobe), 12'h1);
    chk("R10 set_head gated by mode", 12'(set_head), 12'h0);
    go_to(t0 + 4*T + 100);
    x = cyc + 1;
    push_end(x + E, "R7");
    op_write = 1'b0;
    go_to(x);
    chk("R8 write_gate cleared", 12'(write_gate), 12'h0);
    chk("R9 erase held", 12'(erase_gate), 12'h1);
    go_to(x + E - 2);
    chk("R9 erase before expiry", 12'(erase_gate), 12'h1);
    go_to(x + E - 1);
    chk("R9 erase cleared", 12'(erase_gate), 12'h0);
    chk("R7 tg2 during erase tail", 12'(tag_gate2), 12'h1);
    go_to(x + E + 5);

    nchk++;
    if (q.size() != 0) begin
      nfail++;
      $display("FAIL R2: actual %0d pending events expected 0", q.size());
    end
    finished = 1'b1;
    report();
    $finish;
  end
endmodule